// File: doc/BRIEF.md
# Sorted-Table Binary Search Engine

This controller turns a plain single-port memory into a keyed lookup table. It keeps every stored key in strictly ascending order from address zero upward. Each key carries a data word. A search bisects the occupied region. The first probe is at the middle, and each key comparison discards the half that cannot hold the key. The search ends on a match or when the interval is empty. An insert first runs the same search. A new key then makes room for itself by moving every larger entry up one slot, from the top of the table down. A key that is already stored has its data rewritten where it sits.

The memory has one port and takes one access per clock. A lookup therefore costs a bounded number of cycles that depends on the key. An insert costs cycles in proportion to how many entries lie above the new key. Commands arrive on a valid/ready handshake. Each command returns a single-cycle response that carries hit, error, index and data. `busy` stays high for the whole of any command that lasts more than one cycle.

Top module: `sbs_engine`

## Requirements
- R1: After reset the table is empty, `cmd_ready` is 1, `busy` is 0 and `rsp_valid` is 0.
- R2: `cmd_op` 0 is a search and 1 is an insert. A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both 1. Exactly one response follows as a one-cycle `rsp_valid` pulse. In every cycle between the handshake and the response, `busy` is 1 and `cmd_ready` is 0.
- R3: A search for a stored key responds with `rsp_hit`=1. `rsp_index` is the key's position, which equals the count of stored keys smaller than it. `rsp_data` is the key's data word.
- R4: A search for an absent key responds with `rsp_hit`=0. `rsp_index` is the insertion point, which equals the count of stored keys smaller than the searched key.
- R5: Stored keys stay strictly ascending from position 0. Searching the i-th smallest stored key returns index i.
- R6: Inserting a new key into a table that is not full responds with hit 0, error 0 and the new position as index. Every larger key moves up by one position.
- R7: Inserting a stored key replaces its data in place. The response is hit 1, error 0 and the unchanged position. The count and all other positions stay as they were, and this holds even when the table is full.
- R8: Inserting a new key into a full table responds with `rsp_err`=1 and hit 0. The table contents are left unchanged.
- R9: A search on an empty table responds in the cycle right after the handshake, with a miss at index 0.
- R10: Count the handshake cycle as cycle 0. A search of a table holding n>0 keys responds in a cycle L with 2 <= L <= ceil(log2(n+1))+1.
- R11: A new-key insert at position p into n<DEPTH keys responds in a cycle L. L lies between 2(n-p)+2+(n>0 ? 1 : 0) and ceil(log2(n+1))+2(n-p)+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can take a command this cycle |
| cmd_op | input | 1 | 0 = search, 1 = insert |
| cmd_key | input | KEY_W | Key of the command |
| cmd_data | input | DATA_W | Data word for an insert |
| busy | output | 1 | A multi-cycle command is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Key was found in the table |
| rsp_err | output | 1 | Insert refused because the table is full |
| rsp_index | output | $clog2(DEPTH+1) | Position of the key, or its insertion point |
| rsp_data | output | DATA_W | Data of a search hit or of the insert, else 0 |

## Verification
The keys go in under three orderings. Ascending keys always land at the top, so nothing shifts and the search latency alone is measured. Descending keys always land at position zero, so every insert shifts the whole table and the shift latency peaks. A pseudo-random mix with repeated keys interleaves searches, in-place updates and refusals when the table is full. Each stored key is searched again after each phase, and that sweep separates a broken ordering or a lost entry from a merely wrong response. Misses just below the smallest key, just above the largest key and between neighbours check the insertion point at both ends and in the middle.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PROBE    = 3'd1,
    ST_SHIFT_RD = 3'd2,
    ST_SHIFT_WR = 3'd3,
    ST_PLACE    = 3'd4
  } sbs_state_e;

  localparam logic OP_SEARCH = 1'b0;
  localparam logic OP_INSERT = 1'b1;

  // Worst-case compare count for n stored keys: bit length of n.
  function automatic int unsigned probe_steps(input int unsigned n);
    int unsigned s;
    s = 0;
    for (int b = 0; b < 32; b++) begin
      if ((n >> b) != 0) s = b + 1;
    end
    return s;
  endfunction

endpackage

// File: rtl/sbs_mem.sv
module sbs_mem #(
  parameter int KEY_W  = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [KEY_W-1:0]  wkey,
  input  logic [DATA_W-1:0] wdata,
  output logic [KEY_W-1:0]  rkey,
  output logic [DATA_W-1:0] rdata
);

  logic [KEY_W-1:0]  key_arr [DEPTH];
  logic [DATA_W-1:0] dat_arr [DEPTH];

  // Single port: one read or one write per clock, read data registered.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        key_arr[addr] <= wkey;
        dat_arr[addr] <= wdata;
      end else begin
        rkey  <= key_arr[addr];
        rdata <= dat_arr[addr];
      end
    end
  end

endmodule

// File: rtl/sbs_keycmp.sv
module sbs_keycmp #(
  parameter int KEY_W = 16
) (
  input  logic [KEY_W-1:0] probe_key,
  input  logic [KEY_W-1:0] stored_key,
  output logic             key_eq,
  output logic             key_lt
);

  assign key_eq = (probe_key == stored_key);
  assign key_lt = (probe_key <  stored_key);

endmodule

// File: rtl/sbs_bisect.sv
module sbs_bisect #(
  parameter int CW = 5
) (
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  input  logic [CW-1:0] mid,
  input  logic          key_lt,
  output logic [CW-1:0] nxt_lo,
  output logic [CW-1:0] nxt_hi,
  output logic [CW-1:0] nxt_mid,
  output logic          nxt_empty
);

  logic [CW-1:0] span;

  // Interval is [lo, hi): keep the lower half when the key is smaller.
  assign nxt_lo    = key_lt ? lo  : mid + 1'b1;
  assign nxt_hi    = key_lt ? mid : hi;
  assign span      = nxt_hi - nxt_lo;
  assign nxt_mid   = nxt_lo + (span >> 1);
  assign nxt_empty = !(nxt_lo < nxt_hi);

endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int KEY_W  = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH),
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_op,
  input  logic [KEY_W-1:0]  cmd_key,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              cmd_ready,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_err,
  output logic [CW-1:0]     rsp_index,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [KEY_W-1:0]  mem_wkey,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [KEY_W-1:0]  mem_rkey,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [KEY_W-1:0]  probe_key,
  input  logic              key_eq,
  output logic [CW-1:0]     lo,
  output logic [CW-1:0]     hi,
  output logic [CW-1:0]     mid,
  input  logic [CW-1:0]     nxt_lo,
  input  logic [CW-1:0]     nxt_hi,
  input  logic [CW-1:0]     nxt_mid,
  input  logic              nxt_empty,
  output logic [CW-1:0]     occ,
  output logic              evt_accept,
  output logic              evt_update,
  output logic              evt_full_err,
  output logic              evt_place,
  output logic              evt_shift_wr
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  sbs_state_e        st_q;
  logic              op_q;
  logic [KEY_W-1:0]  key_q;
  logic [DATA_W-1:0] data_q;
  logic [CW-1:0]     lo_q, hi_q, mid_q, cnt_q, sh_q, pos_q;
  logic [CW-1:0]     half_cnt, sh_up;
  logic              in_probe, probe_go, probe_miss, table_full;

  assign half_cnt   = cnt_q >> 1;
  assign sh_up      = sh_q + 1'b1;
  assign table_full = (cnt_q == FULL_CNT);
  assign in_probe   = (st_q == ST_PROBE);
  assign probe_go   = in_probe && !key_eq && !nxt_empty;
  assign probe_miss = in_probe && !key_eq &&  nxt_empty;

  assign cmd_ready    = (st_q == ST_IDLE);
  assign busy         = (st_q != ST_IDLE);
  assign evt_accept   = cmd_valid && cmd_ready;
  assign evt_update   = in_probe && key_eq && (op_q == OP_INSERT);
  assign evt_full_err = probe_miss && (op_q == OP_INSERT) && table_full;
  assign evt_place    = (st_q == ST_PLACE);
  assign evt_shift_wr = (st_q == ST_SHIFT_WR);

  assign probe_key = key_q;
  assign lo        = lo_q;
  assign hi        = hi_q;
  assign mid       = mid_q;
  assign occ       = cnt_q;

  // Memory port schedule: exactly one access per state at most.
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wkey  = key_q;
    mem_wdata = data_q;
    unique case (st_q)
      ST_IDLE: begin
        if (evt_accept && cnt_q != '0) begin
          mem_en   = 1'b1;
          mem_addr = half_cnt[AW-1:0];
        end
      end
      ST_PROBE: begin
        if (evt_update) begin
          mem_en   = 1'b1;
          mem_we   = 1'b1;
          mem_addr = mid_q[AW-1:0];
        end else if (probe_go) begin
          mem_en   = 1'b1;
          mem_addr = nxt_mid[AW-1:0];
        end
      end
      ST_SHIFT_RD: begin
        mem_en   = 1'b1;
        mem_addr = sh_q[AW-1:0];
      end
      ST_SHIFT_WR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sh_up[AW-1:0];
        mem_wkey  = mem_rkey;
        mem_wdata = mem_rdata;
      end
      ST_PLACE: begin
        mem_en   = 1'b1;
        mem_we   = 1'b1;
        mem_addr = pos_q[AW-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_SEARCH;
      key_q     <= '0;
      data_q    <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      mid_q     <= '0;
      cnt_q     <= '0;
      sh_q      <= '0;
      pos_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_index <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (evt_accept) begin
            op_q   <= cmd_op;
            key_q  <= cmd_key;
            data_q <= cmd_data;
            lo_q   <= '0;
            hi_q   <= cnt_q;
            mid_q  <= half_cnt;
            if (cnt_q == '0) begin
              if (cmd_op == OP_SEARCH) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= 1'b0;
                rsp_err   <= 1'b0;
                rsp_index <= '0;
                rsp_data  <= '0;
              end else begin
                pos_q <= '0;
                st_q  <= ST_PLACE;
              end
            end else begin
              st_q <= ST_PROBE;
            end
          end
        end
        ST_PROBE: begin
          if (key_eq) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_index <= mid_q;
            rsp_data  <= (op_q == OP_INSERT) ? data_q : mem_rdata;
            st_q      <= ST_IDLE;
          end else if (!nxt_empty) begin
            lo_q  <= nxt_lo;
            hi_q  <= nxt_hi;
            mid_q <= nxt_mid;
          end else if (op_q == OP_SEARCH || table_full) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_err   <= (op_q == OP_INSERT);
            rsp_index <= nxt_lo;
            rsp_data  <= '0;
            st_q      <= ST_IDLE;
          end else begin
            pos_q <= nxt_lo;
            if (nxt_lo == cnt_q) begin
              st_q <= ST_PLACE;
            end else begin
              sh_q <= cnt_q - 1'b1;
              st_q <= ST_SHIFT_RD;
            end
          end
        end
        ST_SHIFT_RD: st_q <= ST_SHIFT_WR;
        ST_SHIFT_WR: begin
          if (sh_q == pos_q) begin
            st_q <= ST_PLACE;
          end else begin
            sh_q <= sh_q - 1'b1;
            st_q <= ST_SHIFT_RD;
          end
        end
        ST_PLACE: begin
          cnt_q     <= cnt_q + 1'b1;
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b0;
          rsp_err   <= 1'b0;
          rsp_index <= pos_q;
          rsp_data  <= data_q;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbs_engine.sv
module sbs_engine #(
  parameter int KEY_W  = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic                       cmd_op,
  input  logic [KEY_W-1:0]           cmd_key,
  input  logic [DATA_W-1:0]          cmd_data,
  output logic                       busy,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic                       rsp_err,
  output logic [$clog2(DEPTH+1)-1:0] rsp_index,
  output logic [DATA_W-1:0]          rsp_data
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic              mem_en, mem_we;
  logic [AW-1:0]     mem_addr;
  logic [KEY_W-1:0]  mem_wkey, mem_rkey, probe_key;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic              key_eq, key_lt;
  logic [CW-1:0]     lo, hi, mid, nxt_lo, nxt_hi, nxt_mid, occ;
  logic              nxt_empty;
  // Named internal events for the bound checker.
  logic              evt_accept, evt_update, evt_full_err, evt_place, evt_shift_wr;

  sbs_mem #(.KEY_W(KEY_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .en(mem_en), .we(mem_we), .addr(mem_addr),
    .wkey(mem_wkey), .wdata(mem_wdata), .rkey(mem_rkey), .rdata(mem_rdata)
  );

  sbs_keycmp #(.KEY_W(KEY_W)) u_cmp (
    .probe_key(probe_key), .stored_key(mem_rkey), .key_eq(key_eq), .key_lt(key_lt)
  );

  sbs_bisect #(.CW(CW)) u_bisect (
    .lo(lo), .hi(hi), .mid(mid), .key_lt(key_lt),
    .nxt_lo(nxt_lo), .nxt_hi(nxt_hi), .nxt_mid(nxt_mid), .nxt_empty(nxt_empty)
  );

  sbs_ctrl #(.KEY_W(KEY_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_key(cmd_key), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
    .rsp_index(rsp_index), .rsp_data(rsp_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wkey(mem_wkey), .mem_wdata(mem_wdata), .mem_rkey(mem_rkey), .mem_rdata(mem_rdata),
    .probe_key(probe_key), .key_eq(key_eq),
    .lo(lo), .hi(hi), .mid(mid),
    .nxt_lo(nxt_lo), .nxt_hi(nxt_hi), .nxt_mid(nxt_mid), .nxt_empty(nxt_empty),
    .occ(occ), .evt_accept(evt_accept), .evt_update(evt_update),
    .evt_full_err(evt_full_err), .evt_place(evt_place), .evt_shift_wr(evt_shift_wr)
  );

endmodule

// File: rtl/sbs_engine_chk.sv
module sbs_engine_chk
  import sbs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_op,
  input logic          evt_accept,
  input logic          evt_update,
  input logic          evt_full_err,
  input logic          evt_place,
  input logic          evt_shift_wr,
  input logic          busy,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_err,
  input logic [CW-1:0] occ
);

  logic          rec_op;
  logic [CW-1:0] rec_occ;
  int unsigned   lat;

  // Cycle count since the handshake cycle of the command in flight.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat     <= 0;
      rec_op  <= OP_SEARCH;
      rec_occ <= '0;
    end else if (evt_accept) begin
      lat     <= 1;
      rec_op  <= cmd_op;
      rec_occ <= occ;
    end else if (rsp_valid) begin
      lat <= 0;
    end else if (lat != 0) begin
      lat <= lat + 1;
    end
  end

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && !(cmd_op == OP_SEARCH && occ == '0)) |=> busy);

  assert_rsp_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);

  assert_place_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_place |=> (rsp_valid && !rsp_hit && !rsp_err && occ == $past(occ) + 1'b1));

  assert_update_in_place_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_update |=> (rsp_valid && rsp_hit && $stable(occ)));

  assert_full_refusal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_full_err |-> (occ == CW'(DEPTH)));

  assert_full_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_full_err |=> (rsp_valid && rsp_err && $stable(occ)));

  assert_occ_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  assert_shift_not_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_shift_wr |-> (occ < CW'(DEPTH)));

  assert_empty_search_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && cmd_op == OP_SEARCH && occ == '0) |=> (rsp_valid && !rsp_hit));

  assert_search_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rec_op == OP_SEARCH) |-> (lat <= probe_steps(32'(rec_occ)) + 1));

  assert_insert_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rec_op == OP_INSERT) |->
      (lat <= probe_steps(32'(rec_occ)) + 2 * 32'(rec_occ) + 2));

endmodule

bind sbs_engine sbs_engine_chk #(.DEPTH(DEPTH), .CW(CW)) u_sbs_chk (
  .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .evt_accept(evt_accept),
  .evt_update(evt_update), .evt_full_err(evt_full_err), .evt_place(evt_place),
  .evt_shift_wr(evt_shift_wr), .busy(busy), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_err(rsp_err), .occ(occ)
);

// File: tb/test_sbs_engine.sv
module test_sbs_engine;

  localparam int KW    = 16;
  localparam int DW    = 16;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam logic SRCH = 1'b0;
  localparam logic INS  = 1'b1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_op = 1'b0;
  logic [KW-1:0] cmd_key = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          busy, rsp_valid, rsp_hit, rsp_err;
  logic [CW-1:0] rsp_index;
  logic [DW-1:0] rsp_data;

  int checks = 0;
  int failures = 0;

  // Reference table, kept sorted by the bench itself.
  int ref_key [DEPTH];
  int ref_dat [DEPTH];
  int ref_n = 0;

  // Captured response.
  int got, lat, busy_bad, r_hit, r_err, r_idx, r_data;

  always #2 clk = ~clk;

  sbs_engine #(.KEY_W(KW), .DATA_W(DW), .DEPTH(DEPTH)) i_sbs_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_key(cmd_key), .cmd_data(cmd_data), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
    .rsp_index(rsp_index), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Halving count: how many times n can be halved before reaching zero.
  function automatic int halvings(input int n);
    int c = 0;
    int v = n;
    while (v > 0) begin v = v / 2; c++; end
    return c;
  endfunction

  function automatic int ref_find(input int k);
    for (int i = 0; i < ref_n; i++) if (ref_key[i] == k) return i;
    return -1;
  endfunction

  function automatic int ref_rank(input int k);
    int r = 0;
    for (int i = 0; i < ref_n; i++) if (ref_key[i] < k) r++;
    return r;
  endfunction

  task automatic do_reset();
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ref_n = 0;
  endtask

  task automatic run_cmd(input logic op, input logic [KW-1:0] k, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_key = k; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    got = 0; lat = 0; busy_bad = 0;
    while (got == 0 && lat < 400) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      lat++;
      if (rsp_valid) begin
        got = 1;
        r_hit = int'(rsp_hit); r_err = int'(rsp_err);
        r_idx = int'(rsp_index); r_data = int'(rsp_data);
      end else if (!busy || cmd_ready) begin
        busy_bad = 1;
      end
    end
  endtask

  task automatic do_op(input logic op, input int k, input int d);
    int n    = ref_n;
    int pos  = ref_find(k);
    int rank = ref_rank(k);
    int sb   = halvings(n);
    int lo_l, hi_l;
    run_cmd(op, k[KW-1:0], d[DW-1:0]);
    chk(got == 1, "R2", "response pulse", got, 1);
    chk(busy_bad == 0, "R2", "busy held, ready low", busy_bad, 0);
    if (op == SRCH) begin
      if (pos >= 0) begin
        chk(r_hit == 1, "R3", "search hit", r_hit, 1);
        chk(r_idx == pos, "R3", "hit index", r_idx, pos);
        chk(r_data == ref_dat[pos], "R3", "hit data", r_data, ref_dat[pos]);
      end else begin
        chk(r_hit == 0, "R4", "search miss", r_hit, 0);
        chk(r_idx == rank, "R4", "insertion point", r_idx, rank);
      end
      if (n == 0) chk(lat == 1, "R9", "empty search latency", lat, 1);
      else chk(lat >= 2 && lat <= sb + 1, "R10", "search latency", lat, sb + 1);
    end else if (pos >= 0) begin
      chk(r_hit == 1 && r_err == 0, "R7", "update hit", r_hit, 1);
      chk(r_idx == pos, "R7", "update index", r_idx, pos);
      chk(lat >= 2 && lat <= sb + 1, "R7", "update latency", lat, sb + 1);
      ref_dat[pos] = d;
    end else if (n == DEPTH) begin
      chk(r_err == 1 && r_hit == 0, "R8", "full refusal", r_err, 1);
      chk(lat >= 2 && lat <= sb + 1, "R8", "refusal latency", lat, sb + 1);
    end else begin
      chk(r_hit == 0 && r_err == 0, "R6", "new insert flags", r_hit + 2 * r_err, 0);
      chk(r_idx == rank, "R6", "new insert index", r_idx, rank);
      lo_l = 2 * (n - rank) + 2 + ((n > 0) ? 1 : 0);
      hi_l = sb + 2 * (n - rank) + 2;
      chk(lat >= lo_l && lat <= hi_l, "R11", "insert latency", lat, hi_l);
      for (int i = n; i > rank; i--) begin
        ref_key[i] = ref_key[i-1];
        ref_dat[i] = ref_dat[i-1];
      end
      ref_key[rank] = k;
      ref_dat[rank] = d;
      ref_n = n + 1;
    end
  endtask

  // R5: every stored key sits at its rank, with its data.
  task automatic verify_table();
    for (int i = 0; i < ref_n; i++) begin
      do_op(SRCH, ref_key[i], 0);
      chk(r_idx == i, "R5", "ordered position", r_idx, i);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(cmd_ready == 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(rsp_valid == 1'b0, "R1", "no response after reset", int'(rsp_valid), 0);
    do_op(SRCH, 16'h1234, 0);
    chk(r_hit == 0 && r_idx == 0, "R1", "table empty", r_idx, 0);
    do_op(SRCH, 16'h0000, 0);
  endtask

  task automatic t_ascending();
    do_reset();
    for (int i = 0; i < 10; i++) do_op(INS, 100 + i * 7, 500 + i);
    verify_table();
    do_op(SRCH, 99, 0);
    do_op(SRCH, 101, 0);
    do_op(SRCH, 200, 0);
    do_op(SRCH, 0, 0);
    do_op(SRCH, 65535, 0);
    do_op(INS, 114, 16'hBEEF);
    verify_table();
  endtask

  task automatic t_descending_full();
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      int k = (i == 0) ? 65535 : ((i == DEPTH - 1) ? 0 : 60000 - i * 3000);
      do_op(INS, k, 1000 + i);
    end
    verify_table();
    do_op(INS, 12345, 7);
    do_op(SRCH, 12345, 0);
    do_op(INS, 65535, 16'h00AA);
    do_op(INS, 0, 16'h0055);
    do_op(INS, 1, 9);
    verify_table();
  endtask

  task automatic t_random_mix();
    logic [15:0] lfsr = 16'hACE1;
    do_reset();
    for (int n = 0; n < 60; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_op((lfsr[1:0] != 2'b00) ? INS : SRCH, int'(lfsr[15:4]) % 24 * 11, int'(lfsr));
    end
    verify_table();
  endtask

  initial begin
    t_reset_state();
    t_ascending();
    t_descending_full();
    t_random_mix();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule